// File: doc/BRIEF.md
# Serial-Scan Array Test Access Controller

This block wraps a 32-word by 32-bit storage array that has two read ports and one write port. It gives a tester direct control of that array over a few slow pins. Normal operation uses a functional interface that runs on the system clock. When the test-mode pin is high, the array is instead driven from a 128-bit serial chain. A tester shifts the port addresses and write data into this chain, steps the array with a separate, slowly pulsed array-clock pin, and shifts the captured read data back out.

Every test pin is sampled on the system clock through a two-stage synchronizer. The block acts on the rising edges of the scan-clock and array-clock pins once they are synchronized, so each pin level must be held for at least three system clocks.

A three-state sequencer sets the order of a read. It has these states and transitions:
- SEQ_IDLE goes to SEQ_ADDR on an array-clock pulse while either read enable is high. The pulse latches the enabled addresses.
- SEQ_ADDR goes to SEQ_DATA on the next pulse. This pulse loads the array's output registers.
- SEQ_DATA goes back to SEQ_IDLE on the next pulse. This pulse copies both read results into the chain.
- Any state goes to SEQ_IDLE while the array-reset pin is high or test mode is low.

A write needs a single pulse in SEQ_IDLE with the write-enable pin high.

Top module: `scan_array_tap`

## Requirements
- R1: In test mode, each scan-clock rising edge shifts the chain up one place and loads the data-in pin into bit 0. The first of 128 bits shifted in ends at bit 127, and the data-out pin always shows bit 127. Pin levels must be held for at least 3 system clocks.
- R2: Scan-clock edges leave the chain unchanged while test mode is low.
- R3: After 128 zero bits have been shifted in, the data-out pin reads 0 on every following shift.
- R4: A read is three array-clock pulses. The first pulse has the read enables high; the second and third have them low. Afterwards, chain bits [122:91] hold the word at the address in bits [127:123], and bits [85:54] hold the word at the address in bits [90:86]. All other chain bits keep the values that were shifted in. Write address is bits [53:49], write data is bits [48:17], and bits [16:0] are unused.
- R5: If only two pulses of a read sequence are given, the read-data fields of the chain are left unchanged.
- R6: An array-clock pulse in SEQ_IDLE with the write-enable pin high stores the write-data field at the write-address field.
- R7: The array-reset pin, while held high in test mode, returns the sequencer to SEQ_IDLE. A later pulse with no enables then captures nothing.
- R8: With test mode low, the functional ports control the array. A write takes effect at the next clock edge. Read data appears two clock edges after the read enable and address are applied. Array-clock pulses have no effect.
- R9: After system reset the chain is all zero, the data-out pin is 0, and both functional read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low system reset |
| tmode_i | input | 1 | Test-mode select pin |
| sclk_i | input | 1 | Scan shift clock pin |
| sdi_i | input | 1 | Scan data in |
| sdo_o | output | 1 | Scan data out (chain bit 127) |
| aclk_i | input | 1 | Array step pulse pin |
| arst_i | input | 1 | Array sequencer reset pin |
| t_rd0_en_i | input | 1 | Test read port 0 enable |
| t_rd1_en_i | input | 1 | Test read port 1 enable |
| t_wr_en_i | input | 1 | Test write enable |
| fn_rd0_en_i | input | 1 | Functional read 0 enable |
| fn_rd0_addr_i | input | 5 | Functional read 0 address |
| fn_rd0_data_o | output | 32 | Read port 0 data |
| fn_rd1_en_i | input | 1 | Functional read 1 enable |
| fn_rd1_addr_i | input | 5 | Functional read 1 address |
| fn_rd1_data_o | output | 32 | Read port 1 data |
| fn_wr_en_i | input | 1 | Functional write enable |
| fn_wr_addr_i | input | 5 | Functional write address |
| fn_wr_data_i | input | 32 | Functional write data |

## Verification
A sequencer stuck in the wrong state is visible only at the next scan-out. The read-data fields then come back either overwritten early or never refreshed. The early-stop and array-reset cases cover both failure modes. A chain bit lost or doubled while shifting shows up as a misaligned pattern at data-out within one full 128-shift unload. A test write that goes to the wrong address is caught by the functional read-back, two clocks after that read is issued.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int CHAIN_W = 128;
    localparam int R0_A_LO = CHAIN_W - ADDR_W;
    localparam int R0_D_LO = R0_A_LO - DATA_W;
    localparam int R1_A_LO = R0_D_LO - ADDR_W;
    localparam int R1_D_LO = R1_A_LO - DATA_W;
    localparam int W_A_LO  = R1_D_LO - ADDR_W;
    localparam int W_D_LO  = W_A_LO - DATA_W;
    localparam int PIN_N   = 8;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_DATA} seq_state_t;
endpackage

// File: rtl/tap_sync.sv
`timescale 1ns/1ps
module tap_sync #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    logic [N-1:0] s1_q, s2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
        end
    end

    assign lvl_o = s2_q;
endmodule

// File: rtl/tap_seq.sv
`timescale 1ns/1ps
module tap_seq
    import scan_tap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tmode_i,
    input  logic step_i,
    input  logic arst_i,
    input  logic rd_req_i,
    output logic ld_addr_o,
    output logic ld_data_o,
    output logic cap_o,
    output logic wr_ok_o
);
    seq_state_t state_q, state_d;
    logic live;

    assign live = step_i & tmode_i & ~arst_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEQ_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!tmode_i || arst_i) begin
            state_d = SEQ_IDLE;
        end else if (step_i) begin
            unique case (state_q)
                SEQ_IDLE: if (rd_req_i) state_d = SEQ_ADDR;
                SEQ_ADDR: state_d = SEQ_DATA;
                SEQ_DATA: state_d = SEQ_IDLE;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_addr_o = 1'b0;
        ld_data_o = 1'b0;
        cap_o     = 1'b0;
        wr_ok_o   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                ld_addr_o = live & rd_req_i;
                wr_ok_o   = live;
            end
            SEQ_ADDR: ld_data_o = live;
            SEQ_DATA: cap_o     = live;
            default: ;
        endcase
    end

    // R8: leaving test mode parks the sequencer
    p_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tmode_i |=> state_q == SEQ_IDLE);
    // R7: array reset pin forces idle
    p_arst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arst_i && tmode_i) |=> state_q == SEQ_IDLE);
    // R5: data state only reached from the address state
    p_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_DATA) |-> ($past(state_q) == SEQ_ADDR || $past(state_q) == SEQ_DATA));
    // R4: capture happens at most once per sequence
    p_onecap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_o |=> !cap_o);
endmodule

// File: rtl/scan_shift.sv
`timescale 1ns/1ps
module scan_shift
    import scan_tap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_en_i,
    input  logic              sdi_i,
    input  logic              cap_en_i,
    input  logic [DATA_W-1:0] rd0_i,
    input  logic [DATA_W-1:0] rd1_i,
    output logic              sdo_o,
    output logic [ADDR_W-1:0] r0_addr_o,
    output logic [ADDR_W-1:0] r1_addr_o,
    output logic [ADDR_W-1:0] w_addr_o,
    output logic [DATA_W-1:0] w_data_o
);
    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else if (shift_en_i) begin
            chain_q <= {chain_q[CHAIN_W-2:0], sdi_i};
        end else if (cap_en_i) begin
            chain_q[R0_D_LO +: DATA_W] <= rd0_i;
            chain_q[R1_D_LO +: DATA_W] <= rd1_i;
        end
    end

    assign sdo_o     = chain_q[CHAIN_W-1];
    assign r0_addr_o = chain_q[R0_A_LO +: ADDR_W];
    assign r1_addr_o = chain_q[R1_A_LO +: ADDR_W];
    assign w_addr_o  = chain_q[W_A_LO +: ADDR_W];
    assign w_data_o  = chain_q[W_D_LO +: DATA_W];

    p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en_i |=> chain_q[CHAIN_W-1:1] == $past(chain_q[CHAIN_W-2:0]));
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_en_i && !cap_en_i) |=> $stable(chain_q));
    p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_en_i && !shift_en_i) |=> ($stable(chain_q[CHAIN_W-1:R0_A_LO])
            && $stable(chain_q[R0_D_LO-1:R1_A_LO]) && $stable(chain_q[R1_D_LO-1:0])));
endmodule

// File: rtl/dual_read_array.sv
`timescale 1ns/1ps
module dual_read_array
    import scan_tap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              ld_a0_i,
    input  logic [ADDR_W-1:0] a0_i,
    input  logic              ld_a1_i,
    input  logic [ADDR_W-1:0] a1_i,
    input  logic              ld_data_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] wa_i,
    input  logic [DATA_W-1:0] wd_i,
    output logic [DATA_W-1:0] rd0_o,
    output logic [DATA_W-1:0] rd1_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] a0_q, a1_q;

    always_ff @(posedge clk_i) begin
        if (we_i) mem[wa_i] <= wd_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a0_q  <= '0;
            a1_q  <= '0;
            rd0_o <= '0;
            rd1_o <= '0;
        end else if (clr_i) begin
            a0_q  <= '0;
            a1_q  <= '0;
            rd0_o <= '0;
            rd1_o <= '0;
        end else begin
            if (ld_a0_i) a0_q <= a0_i;
            if (ld_a1_i) a1_q <= a1_i;
            if (ld_data_i) begin
                rd0_o <= mem[a0_q];
                rd1_o <= mem[a1_q];
            end
        end
    end

    p_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> mem[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/scan_array_tap.sv
`timescale 1ns/1ps
module scan_array_tap
    import scan_tap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tmode_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              aclk_i,
    input  logic              arst_i,
    input  logic              t_rd0_en_i,
    input  logic              t_rd1_en_i,
    input  logic              t_wr_en_i,
    input  logic              fn_rd0_en_i,
    input  logic [ADDR_W-1:0] fn_rd0_addr_i,
    output logic [DATA_W-1:0] fn_rd0_data_o,
    input  logic              fn_rd1_en_i,
    input  logic [ADDR_W-1:0] fn_rd1_addr_i,
    output logic [DATA_W-1:0] fn_rd1_data_o,
    input  logic              fn_wr_en_i,
    input  logic [ADDR_W-1:0] fn_wr_addr_i,
    input  logic [DATA_W-1:0] fn_wr_data_i
);
    logic [PIN_N-1:0] lvl;
    logic [1:0]       prev_q;
    logic tm, shift_en, step, arst_t;
    logic ld_addr, ld_data, cap, wr_ok;
    logic [ADDR_W-1:0] c_r0a, c_r1a, c_wa;
    logic [DATA_W-1:0] c_wd, rd0, rd1;

    tap_sync #(.N(PIN_N)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i ({t_wr_en_i, t_rd1_en_i, t_rd0_en_i, arst_i, aclk_i, sdi_i, sclk_i, tmode_i}),
        .lvl_o (lvl)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= {lvl[3], lvl[1]};
    end

    assign tm       = lvl[0];
    assign shift_en = tm & lvl[1] & ~prev_q[0];
    assign step     = tm & lvl[3] & ~prev_q[1];
    assign arst_t   = tm & lvl[4];

    tap_seq u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tmode_i  (tm),
        .step_i   (step),
        .arst_i   (arst_t),
        .rd_req_i (lvl[5] | lvl[6]),
        .ld_addr_o(ld_addr),
        .ld_data_o(ld_data),
        .cap_o    (cap),
        .wr_ok_o  (wr_ok)
    );

    scan_shift u_chain (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .shift_en_i(shift_en),
        .sdi_i     (lvl[2]),
        .cap_en_i  (cap),
        .rd0_i     (rd0),
        .rd1_i     (rd1),
        .sdo_o     (sdo_o),
        .r0_addr_o (c_r0a),
        .r1_addr_o (c_r1a),
        .w_addr_o  (c_wa),
        .w_data_o  (c_wd)
    );

    dual_read_array u_arr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (arst_t),
        .ld_a0_i  (tm ? (ld_addr & lvl[5]) : fn_rd0_en_i),
        .a0_i     (tm ? c_r0a : fn_rd0_addr_i),
        .ld_a1_i  (tm ? (ld_addr & lvl[6]) : fn_rd1_en_i),
        .a1_i     (tm ? c_r1a : fn_rd1_addr_i),
        .ld_data_i(tm ? ld_data : 1'b1),
        .we_i     (tm ? (wr_ok & lvl[7]) : fn_wr_en_i),
        .wa_i     (tm ? c_wa : fn_wr_addr_i),
        .wd_i     (tm ? c_wd : fn_wr_data_i),
        .rd0_o    (rd0),
        .rd1_o    (rd1)
    );

    assign fn_rd0_data_o = rd0;
    assign fn_rd1_data_o = rd1;

    // R9: data-out low in the first cycle after reset release
    p_rstout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !sdo_o);
endmodule

// File: tb/scan_array_tap_bench.sv
`timescale 1ns/1ps
module scan_array_tap_bench;
    logic clk = 0, rst_n = 0;
    logic tmode = 0, sclk = 0, sdi = 0, sdo, aclk = 0, arst = 0;
    logic t_r0 = 0, t_r1 = 0, t_w = 0;
    logic f_r0 = 0, f_r1 = 0, f_w = 0;
    logic [4:0] f_a0 = 0, f_a1 = 0, f_wa = 0;
    logic [31:0] f_wd = 0, d0, d1;
    int checks = 0, errors = 0;
    logic [31:0] exp_mem [32];
    logic [127:0] got;

    localparam logic [36:0] TBL [8] = '{
        {5'd0,  32'h1357_9BDF}, {5'd1,  32'h0F0F_A0A0}, {5'd7,  32'hC001_D00D},
        {5'd16, 32'h7E57_0016}, {5'd31, 32'hFFFF_0000}, {5'd15, 32'h2468_ACE0},
        {5'd9,  32'h0000_0001}, {5'd22, 32'h8000_0000}};
    localparam logic [31:0] WVAL = 32'hA5C3_1E77;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    scan_array_tap u_scan_array_tap (
        .clk_i(clk), .rst_ni(rst_n), .tmode_i(tmode), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .aclk_i(aclk), .arst_i(arst), .t_rd0_en_i(t_r0),
        .t_rd1_en_i(t_r1), .t_wr_en_i(t_w), .fn_rd0_en_i(f_r0), .fn_rd0_addr_i(f_a0),
        .fn_rd0_data_o(d0), .fn_rd1_en_i(f_r1), .fn_rd1_addr_i(f_a1),
        .fn_rd1_data_o(d1), .fn_wr_en_i(f_w), .fn_wr_addr_i(f_wa), .fn_wr_data_i(f_wd));

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [127:0] frame(input logic [4:0] ra0, input logic [31:0] rd0,
        input logic [4:0] ra1, input logic [31:0] rd1, input logic [4:0] wa, input logic [31:0] wd);
        return {ra0, rd0, ra1, rd1, wa, wd, 17'h0};
    endfunction

    task automatic shift_bit(input logic b);
        sdi = b; waitn(2); sclk = 1; waitn(4); sclk = 0; waitn(2);
    endtask

    task automatic scan_in(input logic [127:0] v);
        for (int i = 127; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic scan_out(output logic [127:0] v);
        v[127] = sdo;
        for (int i = 126; i >= 0; i--) begin
            shift_bit(1'b0);
            v[i] = sdo;
        end
    endtask

    task automatic pulse();
        aclk = 1; waitn(4); aclk = 0; waitn(4);
    endtask

    task automatic fn_write(input logic [4:0] a, input logic [31:0] d);
        f_w = 1; f_wa = a; f_wd = d; @(negedge clk); f_w = 0;
        exp_mem[a] = d;
    endtask

    task automatic fn_read(input logic [4:0] a, input logic [4:0] b);
        f_r0 = 1; f_a0 = a; f_r1 = 1; f_a1 = b;
        @(negedge clk); f_r0 = 0; f_r1 = 0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        waitn(5); rst_n = 1; @(negedge clk);
        // R9 reset state
        chk(sdo == 0, "R9 sdo", 128'(sdo), 0);
        chk(d0 == 0, "R9 rd0", 128'(d0), 0);
        chk(d1 == 0, "R9 rd1", 128'(d1), 0);

        // R8 functional table walk
        for (int i = 0; i < 8; i++) begin
            fn_write(TBL[i][36:32], TBL[i][31:0]);
            fn_read(TBL[i][36:32], TBL[0][36:32]);
            chk(d0 == TBL[i][31:0], "R8 port0", 128'(d0), 128'(TBL[i][31:0]));
            chk(d1 == exp_mem[TBL[0][36:32]], "R8 port1", 128'(d1), 128'(exp_mem[TBL[0][36:32]]));
        end
        // R8 array pulse ignored in functional mode (chain fields are zero)
        t_w = 1; pulse(); t_w = 0;
        fn_read(5'd0, 5'd16);
        chk(d0 == exp_mem[0], "R8 pulse ignored", 128'(d0), 128'(exp_mem[0]));

        tmode = 1; waitn(4);
        // R3 zero flush
        scan_in({128{1'b1}});
        scan_in(128'h0);
        begin
            bit bad = 0;
            if (sdo !== 0) bad = 1;
            for (int i = 0; i < 127; i++) begin
                shift_bit(1'b0);
                if (sdo !== 0) bad = 1;
            end
            chk(!bad, "R3 zero out", 128'(bad), 0);
        end

        // R1 shift order
        scan_in(128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);
        chk(sdo == 1'b1, "R1 first bit", 128'(sdo), 1);
        scan_out(got);
        chk(got == 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978, "R1 pattern",
            got, 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);

        // R2 no shift outside test mode
        scan_in(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        tmode = 0; waitn(4);
        for (int i = 0; i < 10; i++) shift_bit(1'b1);
        tmode = 1; waitn(4);
        scan_out(got);
        chk(got == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R2 held",
            got, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);

        // R6 scan write
        scan_in(frame(0, 0, 0, 0, 5'd15, WVAL));
        t_w = 1; waitn(4); pulse(); t_w = 0; waitn(4);
        exp_mem[15] = WVAL;

        // R4 three-pulse read
        scan_in(frame(5'd15, ONES, 5'd16, ONES, 5'd3, 32'hDEAD_0003));
        t_r0 = 1; t_r1 = 1; waitn(4); pulse();
        t_r0 = 0; t_r1 = 0; waitn(4); pulse(); pulse();
        scan_out(got);
        chk(got[122:91] == exp_mem[15], "R4 r0 data", 128'(got[122:91]), 128'(exp_mem[15]));
        chk(got[85:54] == exp_mem[16], "R4 r1 data", 128'(got[85:54]), 128'(exp_mem[16]));
        chk({got[127:123], got[90:86], got[53:0]} == {5'd15, 5'd16, 5'd3, 32'hDEAD_0003, 17'h0},
            "R4 other fields", got, frame(5'd15, exp_mem[15], 5'd16, exp_mem[16], 5'd3, 32'hDEAD_0003));

        // R5 two pulses only: no capture
        scan_in(frame(5'd15, ONES, 5'd16, ONES, 0, 0));
        t_r0 = 1; t_r1 = 1; waitn(4); pulse();
        t_r0 = 0; t_r1 = 0; waitn(4); pulse();
        scan_out(got);
        chk(got[122:91] == ONES && got[85:54] == ONES, "R5 fields kept",
            got, frame(5'd15, ONES, 5'd16, ONES, 0, 0));

        // R7 array reset clears pending sequence
        scan_in(frame(5'd15, ONES, 5'd16, ONES, 0, 0));
        arst = 1; waitn(4); arst = 0; waitn(4);
        pulse();
        scan_out(got);
        chk(got[122:91] == ONES && got[85:54] == ONES, "R7 no capture",
            got, frame(5'd15, ONES, 5'd16, ONES, 0, 0));

        // R6 read back through functional port
        tmode = 0; waitn(4);
        fn_read(5'd15, 5'd1);
        chk(d0 == WVAL, "R6 stored word", 128'(d0), 128'(WVAL));
        chk(d1 == exp_mem[1], "R6 neighbour intact", 128'(d1), 128'(exp_mem[1]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule